// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns a demodulated, already synchronised infrared receiver line into decoded remote-control frames. It counts clock cycles (one cycle per sample) between consecutive active edges of the line. Each measured gap is sorted into one of four symbols: a leader, a repeat, a logic zero or a logic one. A leader starts a frame. The frame then carries four bytes in this order: address, address complement, command, command complement.

Each byte is paired with the byte that follows it. The pair passes when the bitwise AND of the two bytes is zero. When the command pair passes, the block reports the address and command bytes with a single-cycle strobe. When a pair fails, the block reports the raw 16-bit pair with an error strobe and goes back to waiting for a leader. A repeat gap seen while idle produces its own strobe.

All nominal durations and the tolerance are parameters in sample ticks. Each nominal value is stored as the tick count minus one. The line is assumed clean, so there is no carrier removal and no glitch filter.

Top module: `irpd_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all strobes are low, `addr_out`, `cmd_out` and `err_word` are zero, and the decoder waits for a leader.
- R2: Only active edges are measured. With `ACTIVE_LOW`=1 an active edge is a high-to-low step of `ir_in`. Rising steps and the length of the low mark have no effect on decoding.
- R3: The gap value is the number of cycles between two active edges minus one. A gap hits a symbol when it lies within `TOL` of that symbol's nominal value, both ends included. A gap just outside a window is not a bit.
- R4: A leader gap while idle clears the shift register and the bit count and starts the address byte.
- R5: A repeat gap while idle pulses `repeat_pulse` for one cycle, in the cycle after the edge that ends the gap. The decoder stays idle.
- R6: Bits enter first-received as the MSB. The four bytes arrive in the order address, address complement, command, command complement.
- R7: A pair passes when (first byte AND second byte) equals zero. The test is not a full complement check, so a 0x00/0x00 pair also passes.
- R8: A failing pair pulses `err_pulse` for one cycle. `err_word` then holds {first byte, second byte}, and the decoder returns to idle.
- R9: Inside a frame, a gap that hits neither bit window leaves the shift register and the bit count unchanged. The frame continues.
- R10: After the command pair passes, `frame_valid` pulses for one cycle, in the cycle after the last bit's closing edge. `addr_out` and `cmd_out` then hold the address and command bytes.
- R11: After a passing command pair, the next active edge is consumed without being classified. Only the edge after it may start a frame.
- R12: The gap counter stops at its all-ones value, so a very long gap can never wrap into a valid window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated, synchronised receiver line |
| frame_valid | output | 1 | One-cycle strobe for a good frame |
| addr_out | output | BYTE_W | Address byte of the last good frame |
| cmd_out | output | BYTE_W | Command byte of the last good frame |
| repeat_pulse | output | 1 | One-cycle strobe for a repeat gap |
| err_pulse | output | 1 | One-cycle strobe for a failed pair check |
| err_word | output | 2*BYTE_W | Failing pair, first byte in the upper half |

## Verification
A wrong state or bit count inside the block shows at the ports in one of three ways: a strobe that goes missing, a strobe in the wrong cycle, or wrong held bytes. These appear no later than the edge that ends the affected byte pair. A shifted bit order appears at once in `addr_out`, `cmd_out` or `err_word`. An error in the stop-edge handling or in the counter limit shows as an extra or missing `frame_valid` on the following frame. The reference model is compared every cycle, so a deviation is caught in the first cycle it reaches a port.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_ADDR_N = 3'd2,
    ST_CMD    = 3'd3,
    ST_CMD_N  = 3'd4,
    ST_STOP   = 3'd5
  } frame_state_e;

  // symbol slots in the classifier hit vector
  localparam int NUM_SYM  = 4;
  localparam int IDX_LEAD = 0;
  localparam int IDX_REP  = 1;
  localparam int IDX_ZERO = 2;
  localparam int IDX_ONE  = 3;

endpackage

// File: rtl/irpd_edge.sv
// Active-edge detector and saturating gap counter.
module irpd_edge #(
  parameter int unsigned CNT_W      = 16,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ir_in,
  output logic             act_edge,
  output logic [CNT_W-1:0] gap
);

  localparam logic             ACT_LVL = ACTIVE_LOW ? 1'b0 : 1'b1;
  localparam logic [CNT_W-1:0] GAP_MAX = '1;

  logic ir_q;

  assign act_edge = (ir_in == ACT_LVL) && (ir_q != ACT_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= ~ACT_LVL;
      gap  <= '0;
    end else begin
      ir_q <= ir_in;
      if (act_edge)
        gap <= '0;
      else if (gap != GAP_MAX)
        gap <= gap + 1'b1;
    end
  end

endmodule

// File: rtl/irpd_window.sv
// Inclusive tolerance window around one nominal gap value.
module irpd_window #(
  parameter int unsigned W   = 16,
  parameter int unsigned NOM = 100,
  parameter int unsigned TOL = 4
) (
  input  logic [W-1:0] len,
  output logic         hit
);

  localparam int unsigned LO = (NOM > TOL) ? NOM - TOL : 0;
  localparam int unsigned HI = NOM + TOL;

  logic [31:0] len_x;

  assign len_x = 32'(len);
  assign hit   = (len_x >= LO) && (len_x <= HI);

endmodule

// File: rtl/irpd_classify.sv
// One window per symbol, built by a generate loop.
module irpd_classify
  import irpd_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LEAD_T = 1349,
  parameter int unsigned REP_T  = 1124,
  parameter int unsigned ZERO_T = 111,
  parameter int unsigned ONE_T  = 224,
  parameter int unsigned TOL    = 10
) (
  input  logic [CNT_W-1:0]   len,
  output logic [NUM_SYM-1:0] hit
);

  for (genvar g = 0; g < NUM_SYM; g++) begin : g_win
    localparam int unsigned NOM = (g == IDX_LEAD) ? LEAD_T :
                                  (g == IDX_REP)  ? REP_T  :
                                  (g == IDX_ZERO) ? ZERO_T : ONE_T;
    irpd_window #(
      .W  (CNT_W),
      .NOM(NOM),
      .TOL(TOL)
    ) u_win (
      .len(len),
      .hit(hit[g])
    );
  end

endmodule

// File: rtl/irpd_frame.sv
// Frame sequencer: shifting, pair checks and result registers.
module irpd_frame
  import irpd_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PAIR_W   = 2 * BYTE_W,
  parameter int unsigned CNT_BITS = $clog2(PAIR_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                act_edge,
  input  logic [NUM_SYM-1:0]  hit,
  output logic                frame_valid,
  output logic [BYTE_W-1:0]   addr_out,
  output logic [BYTE_W-1:0]   cmd_out,
  output logic                repeat_pulse,
  output logic                err_pulse,
  output logic [PAIR_W-1:0]   err_word,
  output frame_state_e        state,
  output logic [CNT_BITS-1:0] bit_cnt
);

  logic [PAIR_W-1:0]   shreg;
  logic [BYTE_W-1:0]   addr_hold;
  logic                is_bit;
  logic [PAIR_W-1:0]   sh_next;
  logic [CNT_BITS-1:0] cnt_next;
  logic                pair_ok;

  assign is_bit   = hit[IDX_ZERO] | hit[IDX_ONE];
  assign sh_next  = {shreg[PAIR_W-2:0], hit[IDX_ONE]};
  assign cnt_next = bit_cnt + 1'b1;
  assign pair_ok  = (sh_next[PAIR_W-1:BYTE_W] & sh_next[BYTE_W-1:0]) == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      shreg        <= '0;
      bit_cnt      <= '0;
      addr_hold    <= '0;
      frame_valid  <= 1'b0;
      repeat_pulse <= 1'b0;
      err_pulse    <= 1'b0;
      addr_out     <= '0;
      cmd_out      <= '0;
      err_word     <= '0;
    end else begin
      frame_valid  <= 1'b0;
      repeat_pulse <= 1'b0;
      err_pulse    <= 1'b0;
      if (act_edge) begin
        unique case (state)
          ST_IDLE: begin
            if (hit[IDX_LEAD]) begin
              shreg   <= '0;
              bit_cnt <= '0;
              state   <= ST_ADDR;
            end else if (hit[IDX_REP]) begin
              repeat_pulse <= 1'b1;
              shreg        <= '0;
              bit_cnt      <= '0;
            end
          end
          ST_ADDR, ST_CMD: begin
            if (is_bit) begin
              shreg   <= sh_next;
              bit_cnt <= cnt_next;
              if (cnt_next == CNT_BITS'(BYTE_W))
                state <= (state == ST_ADDR) ? ST_ADDR_N : ST_CMD_N;
            end
          end
          ST_ADDR_N, ST_CMD_N: begin
            if (is_bit) begin
              if (cnt_next == CNT_BITS'(PAIR_W)) begin
                shreg   <= '0;
                bit_cnt <= '0;
                if (!pair_ok) begin
                  err_pulse <= 1'b1;
                  err_word  <= sh_next;
                  state     <= ST_IDLE;
                end else if (state == ST_ADDR_N) begin
                  addr_hold <= sh_next[PAIR_W-1:BYTE_W];
                  state     <= ST_CMD;
                end else begin
                  addr_out    <= addr_hold;
                  cmd_out     <= sh_next[PAIR_W-1:BYTE_W];
                  frame_valid <= 1'b1;
                  state       <= ST_STOP;
                end
              end else begin
                shreg   <= sh_next;
                bit_cnt <= cnt_next;
              end
            end
          end
          ST_STOP: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/irpd_decoder.sv
// Top: edge timing, symbol classification, frame sequencing.
module irpd_decoder
  import irpd_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter bit          ACTIVE_LOW = 1'b1,
  parameter int unsigned LEAD_T     = 1349,
  parameter int unsigned REP_T      = 1124,
  parameter int unsigned ZERO_T     = 111,
  parameter int unsigned ONE_T      = 224,
  parameter int unsigned TOL        = 10,
  parameter int unsigned BYTE_W     = 8,
  localparam int unsigned PAIR_W    = 2 * BYTE_W,
  localparam int unsigned CNT_BITS  = $clog2(PAIR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_in,
  output logic              frame_valid,
  output logic [BYTE_W-1:0] addr_out,
  output logic [BYTE_W-1:0] cmd_out,
  output logic              repeat_pulse,
  output logic              err_pulse,
  output logic [PAIR_W-1:0] err_word
);

  logic                act_edge;
  logic [CNT_W-1:0]    gap;
  logic [NUM_SYM-1:0]  hit;
  frame_state_e        state;
  logic [CNT_BITS-1:0] bit_cnt;

  irpd_edge #(
    .CNT_W     (CNT_W),
    .ACTIVE_LOW(ACTIVE_LOW)
  ) u_edge (
    .clk     (clk),
    .rst     (rst),
    .ir_in   (ir_in),
    .act_edge(act_edge),
    .gap     (gap)
  );

  irpd_classify #(
    .CNT_W (CNT_W),
    .LEAD_T(LEAD_T),
    .REP_T (REP_T),
    .ZERO_T(ZERO_T),
    .ONE_T (ONE_T),
    .TOL   (TOL)
  ) u_cls (
    .len(gap),
    .hit(hit)
  );

  irpd_frame #(
    .BYTE_W(BYTE_W)
  ) u_frame (
    .clk         (clk),
    .rst         (rst),
    .act_edge    (act_edge),
    .hit         (hit),
    .frame_valid (frame_valid),
    .addr_out    (addr_out),
    .cmd_out     (cmd_out),
    .repeat_pulse(repeat_pulse),
    .err_pulse   (err_pulse),
    .err_word    (err_word),
    .state       (state),
    .bit_cnt     (bit_cnt)
  );

endmodule

// File: rtl/irpd_decoder_chk.sv
module irpd_decoder_chk
  import irpd_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PAIR_W   = 2 * BYTE_W,
  parameter int unsigned CNT_BITS = $clog2(PAIR_W + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                act_edge,
  input logic [CNT_W-1:0]    gap,
  input frame_state_e        state,
  input logic [CNT_BITS-1:0] bit_cnt,
  input logic                frame_valid,
  input logic                repeat_pulse,
  input logic                err_pulse,
  input logic [PAIR_W-1:0]   err_word
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == ST_IDLE && !frame_valid && !err_pulse && !repeat_pulse)); // R1

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    act_edge |=> gap == '0); // R2

  AST_GAP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !act_edge |=> gap >= $past(gap)); // R12

  AST_REPEAT_IDLE: assert property (@(posedge clk) disable iff (rst)
    repeat_pulse |-> state == ST_IDLE); // R5

  AST_ERR_PAIR_BAD: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> ((err_word[PAIR_W-1:BYTE_W] & err_word[BYTE_W-1:0]) != '0)); // R8

  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> state == ST_IDLE); // R8

  AST_VALID_STOP: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> state == ST_STOP); // R11

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid); // R10

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_valid, repeat_pulse, err_pulse})); // R7

  always @(posedge clk) begin
    if (!rst) begin
      AST_CNT_RANGE: assert (bit_cnt <= CNT_BITS'(PAIR_W)); // R6
    end
  end

endmodule

bind irpd_decoder irpd_decoder_chk #(
  .CNT_W (CNT_W),
  .BYTE_W(BYTE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .act_edge    (act_edge),
  .gap         (gap),
  .state       (state),
  .bit_cnt     (bit_cnt),
  .frame_valid (frame_valid),
  .repeat_pulse(repeat_pulse),
  .err_pulse   (err_pulse),
  .err_word    (err_word)
);

// File: tb/irpd_decoder_tb.sv
`timescale 1ns/1ps
module irpd_decoder_tb;

  localparam int CNT_W  = 8;
  localparam int LEAD_T = 134;
  localparam int REP_T  = 111;
  localparam int ZERO_T = 11;
  localparam int ONE_T  = 23;
  localparam int TOL    = 3;
  localparam int GMAX   = 255;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ir_in = 1'b1;
  logic       frame_valid, repeat_pulse, err_pulse;
  logic [7:0] addr_out, cmd_out;
  logic [15:0] err_word;

  int n_checks = 0;
  int n_errors = 0;
  int n_valid = 0, n_rep = 0, n_err = 0;

  always #5 clk = ~clk;

  irpd_decoder #(
    .CNT_W(CNT_W), .ACTIVE_LOW(1'b1), .LEAD_T(LEAD_T), .REP_T(REP_T),
    .ZERO_T(ZERO_T), .ONE_T(ONE_T), .TOL(TOL), .BYTE_W(8)
  ) u_dut (
    .clk(clk), .rst(rst), .ir_in(ir_in), .frame_valid(frame_valid),
    .addr_out(addr_out), .cmd_out(cmd_out), .repeat_pulse(repeat_pulse),
    .err_pulse(err_pulse), .err_word(err_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, evaluated at each rising edge
  int          m_gap = 0, m_cnt = 0, m_phase = 0;
  logic        m_prev = 1'b1;
  logic [15:0] m_acc = '0;
  logic [7:0]  m_addr = '0;
  logic        e_valid = 0, e_rep = 0, e_err = 0;
  logic [7:0]  e_addr = '0, e_cmd = '0;
  logic [15:0] e_word = '0;
  bit          started = 0;

  function automatic bit near(int g, int nom);
    return (g >= nom - TOL) && (g <= nom + TOL);
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_gap = 0; m_cnt = 0; m_phase = 0; m_prev = 1'b1; m_acc = '0; m_addr = '0;
      e_valid = 0; e_rep = 0; e_err = 0; e_addr = '0; e_cmd = '0; e_word = '0;
    end else begin
      e_valid = 0; e_rep = 0; e_err = 0;
      if (ir_in == 1'b0 && m_prev == 1'b1) begin
        if (m_phase == 0) begin
          if (near(m_gap, LEAD_T)) begin m_phase = 1; m_acc = '0; m_cnt = 0; end
          else if (near(m_gap, REP_T)) begin e_rep = 1; m_acc = '0; m_cnt = 0; end
        end else if (m_phase == 5) begin
          m_phase = 0;
        end else if (near(m_gap, ZERO_T) || near(m_gap, ONE_T)) begin
          m_acc = {m_acc[14:0], near(m_gap, ONE_T)};
          m_cnt++;
          if (m_cnt == 8) m_phase++;
          else if (m_cnt == 16) begin
            if ((m_acc[15:8] & m_acc[7:0]) != 0) begin
              e_err = 1; e_word = m_acc; m_phase = 0;
            end else if (m_phase == 2) begin
              m_addr = m_acc[15:8]; m_phase = 3;
            end else begin
              e_valid = 1; e_addr = m_addr; e_cmd = m_acc[15:8]; m_phase = 5;
            end
            m_acc = '0; m_cnt = 0;
          end
        end
        m_gap = 0;
      end else if (m_gap < GMAX) begin
        m_gap++;
      end
      m_prev = ir_in;
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R10 frame_valid", 32'(frame_valid), 32'(e_valid));
      chk("R5 repeat_pulse", 32'(repeat_pulse), 32'(e_rep));
      chk("R8 err_pulse", 32'(err_pulse), 32'(e_err));
      chk("R6 addr_out", 32'(addr_out), 32'(e_addr));
      chk("R6 cmd_out", 32'(cmd_out), 32'(e_cmd));
      chk("R8 err_word", 32'(err_word), 32'(e_word));
      if (frame_valid) n_valid++;
      if (repeat_pulse) n_rep++;
      if (err_pulse) n_err++;
    end
  end

  task automatic pulse(input int tot, input int mark);
    ir_in = 1'b0;
    repeat (mark) @(negedge clk);
    ir_in = 1'b1;
    repeat (tot - mark) @(negedge clk);
  endtask

  // style 0 nominal, 1 out-of-window gaps inserted, 2 upper window edge, 3 lower window edge
  task automatic send_frame(input logic [7:0] a, input logic [7:0] ai,
                            input logic [7:0] c, input logic [7:0] ci,
                            input int style, input bit stop, input int lead_tot);
    logic [31:0] w;
    w = {a, ai, c, ci};
    pulse(lead_tot, 90);
    for (int i = 31; i >= 0; i--) begin
      case (style)
        2: pulse(w[i] ? ONE_T + 1 + TOL : ZERO_T + 1 + TOL, 10);
        3: pulse(w[i] ? ONE_T + 1 - TOL : ZERO_T + 1 - TOL, 3);
        default: pulse(w[i] ? ONE_T + 1 : ZERO_T + 1, 6);
      endcase
      if (style == 1 && (i % 4) == 0)
        pulse((i % 8) == 0 ? ZERO_T + TOL + 2 : ZERO_T - TOL, 4);
    end
    if (stop) pulse(40, 6);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    ir_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    chk("R1 frame_valid", 32'(frame_valid), 0);
    chk("R1 repeat_pulse", 32'(repeat_pulse), 0);
    chk("R1 err_pulse", 32'(err_pulse), 0);
    chk("R1 addr_out", 32'(addr_out), 0);
    chk("R1 cmd_out", 32'(cmd_out), 0);
    chk("R1 err_word", 32'(err_word), 0);
    rst = 1'b0;
    repeat (50) @(negedge clk);

    // R4 R6 R10: nominal frame
    send_frame(8'hA5, 8'h5A, 8'h3C, 8'hC3, 0, 1, LEAD_T + 1);
    repeat (20) @(negedge clk);
    chk("R10 valid count", 32'(n_valid), 1);
    chk("R6 address", 32'(addr_out), 32'hA5);
    chk("R6 command", 32'(cmd_out), 32'h3C);

    // R5: repeat gap then stop mark
    pulse(REP_T + 1, 90);
    pulse(40, 6);
    repeat (20) @(negedge clk);
    chk("R5 repeat count", 32'(n_rep), 1);
    chk("R5 no frame", 32'(n_valid), 1);

    // R8: address pair fails (0x12 & 0x13 != 0)
    send_frame(8'h12, 8'h13, 8'h40, 8'hBF, 0, 1, LEAD_T + 1);
    repeat (20) @(negedge clk);
    chk("R8 error count", 32'(n_err), 1);
    chk("R8 error word", 32'(err_word), 32'h1213);
    chk("R8 no frame", 32'(n_valid), 1);

    // R7: zero pair passes the AND test
    send_frame(8'h00, 8'h00, 8'hFF, 8'h00, 0, 1, LEAD_T + 1);
    repeat (20) @(negedge clk);
    chk("R7 valid count", 32'(n_valid), 2);
    chk("R7 command", 32'(cmd_out), 32'hFF);

    // R9: out-of-window gaps just past both edges of the zero window
    send_frame(8'h81, 8'h7E, 8'h96, 8'h69, 1, 1, LEAD_T + 1);
    repeat (20) @(negedge clk);
    chk("R9 valid count", 32'(n_valid), 3);
    chk("R9 address", 32'(addr_out), 32'h81);
    chk("R9 command", 32'(cmd_out), 32'h96);

    // R3 R2: window edges with differing mark lengths
    send_frame(8'hC1, 8'h3E, 8'h0F, 8'hF0, 2, 1, LEAD_T + 1 + TOL);
    repeat (20) @(negedge clk);
    chk("R3 upper edge count", 32'(n_valid), 4);
    chk("R3 upper edge cmd", 32'(cmd_out), 32'h0F);
    send_frame(8'h5C, 8'hA3, 8'h71, 8'h8E, 3, 1, LEAD_T + 1 - TOL);
    repeat (20) @(negedge clk);
    chk("R3 lower edge count", 32'(n_valid), 5);
    chk("R2 lower edge addr", 32'(addr_out), 32'h5C);

    // R11: a leader straight after the last bit is eaten by the stop edge
    send_frame(8'h11, 8'hEE, 8'h22, 8'hDD, 0, 0, LEAD_T + 1);
    send_frame(8'h33, 8'hCC, 8'h44, 8'hBB, 0, 1, LEAD_T + 1);
    repeat (20) @(negedge clk);
    chk("R11 valid count", 32'(n_valid), 6);
    chk("R11 address kept", 32'(addr_out), 32'h11);

    // R12: gap of 391 cycles would wrap to the leader value without saturation
    send_frame(8'h66, 8'h99, 8'h55, 8'hAA, 0, 1, 256 + LEAD_T + 1);
    repeat (20) @(negedge clk);
    chk("R12 no frame", 32'(n_valid), 6);
    chk("R12 address unchanged", 32'(addr_out), 32'h11);

    // recovery after saturation
    send_frame(8'h24, 8'hDB, 8'h18, 8'hE7, 0, 1, LEAD_T + 1);
    repeat (20) @(negedge clk);
    chk("R4 recovery count", 32'(n_valid), 7);
    chk("R4 recovery cmd", 32'(cmd_out), 32'h18);
    chk("R8 total errors", 32'(n_err), 1);

    finish_run();
  end

endmodule